// File: doc/BRIEF.md
# Banked Interrupt Controller Register File

This block is the register side of an interrupt controller for a 32-bit processor bus. Interrupt lines come in groups of 32 (a bank). Each line is level sensitive: it is pending while its input is high or while software has forced it. Every line has its own 6-bit priority and a routing bit that sends it to the normal (IRQ) or the fast (FIQ) request output. Each bank has a mask, with separate write-to-clear and write-to-set forms, and a software-forced word, also with set and clear forms.

The priority arbitration is done outside this block. The block presents the pending-and-unmasked vectors of both classes and the priorities of all lines. It takes back the number of the winning line for each class. When an armed output sees any unmasked pending line of its class, the block stores the number it is given, raises the output and disarms it. The output then stays high, and the stored number stays the same, until software writes the new-agreement bit for that class. That write drops the output and re-arms it. A global mask holds off any new assertion. The bus reads combinationally: `rd_data` follows `req_addr` in the same cycle, and a write is taken on the rising clock edge while `req_wr` is high.

Top module: `bank_irq_ctrl`

## Requirements
- R1: After reset, the identification word at 0x00 reads 0x21 and the status word at 0x14 reads 1. Every bank mask reads 0xFFFFFFFF, the source words at 0x40 and 0x44 read 0, and both `irq_out` and `fiq_out` are low.
- R2: In the configuration word at 0x10, bit 0 is an idle setting that reads back. Writing a 1 to bit 1 returns every register of the block to its R1 state on that clock edge, including the idle setting and the line registers.
- R3: Bank b has its words at 0x80 + 0x20·b. Offset +0x00 reads the raw input lines. Offset +0x18 reads (input OR forced) AND NOT mask AND NOT route-to-FIQ. Offset +0x1C reads the same term with route-to-FIQ. Bit i of a bank word is line 32·b + i. The `pend_irq` and `pend_fiq` ports carry the same vectors and never share a set bit.
- R4: Writing bank offset +0x04 replaces the mask. Ones written to +0x08 clear mask bits, and ones written to +0x0C set mask bits. Both aliases read 0.
- R5: Ones written to bank offset +0x10 set software-forced bits, which read back at +0x10. Ones written to +0x14 clear them, and +0x14 reads 0. A forced bit makes its line pending as if its input were high.
- R6: Line n has a word at 0x100 + 4·n. Bits [7:2] hold the priority, and bit 0 routes the line to FIQ when 1 and to IRQ when 0. The word reads back with the other bits 0. The priority appears on `line_prio[6n+5:6n]`.
- R7: When an output is armed, the global mask is off and its pending vector is nonzero at a clock edge, then on that edge the output rises, the arbiter number for that class is stored (read at 0x40 for IRQ, 0x44 for FIQ) and the output is disarmed.
- R8: A raised output and its stored number hold until a write to 0x48 with bit 0 (IRQ) or bit 1 (FIQ) set. That write drops the output and re-arms it. If the class still has a pending line, the output rises again on the next edge with the arbiter number current at that edge.
- R9: Bit 2 of the control word at 0x48 is a global mask that reads back. While it is set, neither output can rise.
- R10: Bank words of a bank index not built, and line words of a line number not built, read as 0. Writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| req_wr | input | 1 | Write strobe for the addressed word |
| req_addr | input | 12 | Byte address of the register word |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data for `req_addr`, combinational |
| int_lines | input | NUM_LINES | Level-sensitive interrupt inputs |
| arb_irq_id | input | SRC_W | Winning IRQ line number from the arbiter |
| arb_fiq_id | input | SRC_W | Winning FIQ line number from the arbiter |
| pend_irq | output | NUM_LINES | Unmasked pending lines routed to IRQ |
| pend_fiq | output | NUM_LINES | Unmasked pending lines routed to FIQ |
| line_prio | output | 6·NUM_LINES | Priority of every line, line n in bits [6n+5:6n] |
| irq_out | output | 1 | IRQ request to the processor |
| fiq_out | output | 1 | FIQ request to the processor |

## Verification
The bench builds the block with NUM_BANKS = 2, which gives 64 lines and a 6-bit source number. This puts a second bank within reach, so bank addressing and the bit-to-line numbering beyond line 31 can be checked. It also leaves a bank index (2) and a line range (from 64 up) that do not exist. Probing those addresses can show decode aliasing onto bank 0 or line 0. The bench itself acts as the arbiter, so it can change the offered number while an output is held and show that the number is stored only at a firing edge.

// File: rtl/birq_pkg.sv
// Shared constants for the banked interrupt controller register file.
// Assumes byte addresses of 12 bits and 32-bit register words.
package birq_pkg;
    localparam int BANK_W   = 32;
    localparam int PRIO_W   = 6;
    localparam int ADDR_W   = 12;
    localparam logic [31:0] REV_VAL = 32'h0000_0021;

    localparam logic [ADDR_W-1:0] A_REV   = 12'h000;
    localparam logic [ADDR_W-1:0] A_CFG   = 12'h010;
    localparam logic [ADDR_W-1:0] A_STAT  = 12'h014;
    localparam logic [ADDR_W-1:0] A_SIRQ  = 12'h040;
    localparam logic [ADDR_W-1:0] A_SFIQ  = 12'h044;
    localparam logic [ADDR_W-1:0] A_CTL   = 12'h048;
    localparam int BANK_BASE_BLK = 4;      // 0x80 >> 5
    localparam int LINE_BASE     = 'h100;

    // word index inside a bank block
    typedef enum logic [2:0] {
        S_RAW  = 3'd0, S_MASK = 3'd1, S_MCLR = 3'd2, S_MSET = 3'd3,
        S_SSET = 3'd4, S_SCLR = 3'd5, S_PIRQ = 3'd6, S_PFIQ = 3'd7
    } bank_sub_e;
endpackage

// File: rtl/birq_bank_regs.sv
// One bank of mask and software-forced bits.
// Assumes at most one of the write strobes is high in a cycle.
module birq_bank_regs
    import birq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_mask,
    input  logic              wr_mclr,
    input  logic              wr_mset,
    input  logic              wr_sset,
    input  logic              wr_sclr,
    input  logic [BANK_W-1:0] wdata,
    output logic [BANK_W-1:0] mask_q,
    output logic [BANK_W-1:0] soft_q
);
    // mask word: full write, clear alias, set alias
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) mask_q <= '1;
        else if (wr_mask)       mask_q <= wdata;
        else if (wr_mclr)       mask_q <= mask_q & ~wdata;
        else if (wr_mset)       mask_q <= mask_q | wdata;
    end

    // software-forced word: set and clear aliases
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) soft_q <= '0;
        else if (wr_sset)       soft_q <= soft_q | wdata;
        else if (wr_sclr)       soft_q <= soft_q & ~wdata;
    end
endmodule

// File: rtl/birq_line_cfg.sv
// Priority and routing store for one interrupt line.
// Assumes cfg_in packs {priority[5:0], route_to_fiq}.
module birq_line_cfg
    import birq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [PRIO_W:0]   cfg_in,
    output logic [PRIO_W-1:0] prio_q,
    output logic              to_fiq_q
);
    // store priority and route on a write to this line's word
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            prio_q   <= '0;
            to_fiq_q <= 1'b0;
        end else if (wr_en) begin
            prio_q   <= cfg_in[PRIO_W:1];
            to_fiq_q <= cfg_in[0];
        end
    end
endmodule

// File: rtl/birq_agree.sv
// Arming handshake for one request output class.
// Fires once per agreement cycle and holds until software re-arms it.
module birq_agree #(
    parameter int SRC_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             soft_rst,
    input  logic             rearm,
    input  logic             gmask,
    input  logic             any_pend,
    input  logic [SRC_W-1:0] arb_src,
    output logic             out_q,
    output logic [SRC_W-1:0] src_q
);
    logic armed_q;

    // arm / fire / capture sequence
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            armed_q <= 1'b1;
            out_q   <= 1'b0;
            src_q   <= '0;
        end else if (rearm) begin
            armed_q <= 1'b1;
            out_q   <= 1'b0;
        end else if (armed_q && any_pend && !gmask) begin
            armed_q <= 1'b0;
            out_q   <= 1'b1;
            src_q   <= arb_src;
        end
    end
endmodule

// File: rtl/bank_irq_ctrl.sv
// Banked interrupt controller register file (top).
// Level-sensitive lines in banks of 32; arbitration is external.
// Reads are combinational from req_addr; writes are taken on the clock edge.
module bank_irq_ctrl
    import birq_pkg::*;
#(
    parameter  int NUM_BANKS = 1,
    localparam int NUM_LINES = NUM_BANKS * BANK_W,
    localparam int SRC_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_wr,
    input  logic [ADDR_W-1:0]             req_addr,
    input  logic [31:0]                   req_wdata,
    output logic [31:0]                   rd_data,
    input  logic [NUM_LINES-1:0]          int_lines,
    input  logic [SRC_W-1:0]              arb_irq_id,
    input  logic [SRC_W-1:0]              arb_fiq_id,
    output logic [NUM_LINES-1:0]          pend_irq,
    output logic [NUM_LINES-1:0]          pend_fiq,
    output logic [NUM_LINES*PRIO_W-1:0]   line_prio,
    output logic                          irq_out,
    output logic                          fiq_out
);
    logic                 soft_rst, rearm_irq, rearm_fiq, ctl_wr;
    logic                 gmask_q, idle_q;
    logic [SRC_W-1:0]     irq_src_q, fiq_src_q;
    logic [NUM_LINES-1:0] mask_all, soft_all, fiq_sel;
    logic [NUM_BANKS-1:0] bank_hit;
    logic [NUM_LINES-1:0] line_hit;
    logic [PRIO_W-1:0]    prio_arr [NUM_LINES];
    logic [2:0]           sub;

    assign ctl_wr    = req_wr && (req_addr == A_CTL);
    assign soft_rst  = req_wr && (req_addr == A_CFG) && req_wdata[1];
    assign rearm_irq = ctl_wr && req_wdata[0];
    assign rearm_fiq = ctl_wr && req_wdata[1];
    assign sub       = req_addr[4:2];

    // global mask and idle setting
    always_ff @(posedge clk) begin
        if (!rst_n || soft_rst) begin
            gmask_q <= 1'b0;
            idle_q  <= 1'b0;
        end else begin
            if (ctl_wr) gmask_q <= req_wdata[2];
            if (req_wr && req_addr == A_CFG) idle_q <= req_wdata[0];
        end
    end

    // one register bank per 32 lines
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic bw;
        assign bank_hit[b] = (req_addr[ADDR_W-1:5] == 7'(BANK_BASE_BLK + b))
                             && (req_addr[1:0] == 2'b00);
        assign bw = req_wr && bank_hit[b];
        birq_bank_regs u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .wr_mask  (bw && sub == S_MASK),
            .wr_mclr  (bw && sub == S_MCLR),
            .wr_mset  (bw && sub == S_MSET),
            .wr_sset  (bw && sub == S_SSET),
            .wr_sclr  (bw && sub == S_SCLR),
            .wdata    (req_wdata),
            .mask_q   (mask_all[b*BANK_W +: BANK_W]),
            .soft_q   (soft_all[b*BANK_W +: BANK_W])
        );
    end

    // one configuration word per line
    for (genvar n = 0; n < NUM_LINES; n++) begin : g_line
        assign line_hit[n] = (req_addr == ADDR_W'(LINE_BASE + 4 * n));
        birq_line_cfg u_cfg (
            .clk      (clk),
            .rst_n    (rst_n),
            .soft_rst (soft_rst),
            .wr_en    (req_wr && line_hit[n]),
            .cfg_in   ({req_wdata[PRIO_W+1:2], req_wdata[0]}),
            .prio_q   (prio_arr[n]),
            .to_fiq_q (fiq_sel[n])
        );
        assign line_prio[n*PRIO_W +: PRIO_W] = prio_arr[n];
    end

    // pending vectors per class
    assign pend_irq = (int_lines | soft_all) & ~mask_all & ~fiq_sel;
    assign pend_fiq = (int_lines | soft_all) & ~mask_all &  fiq_sel;

    birq_agree #(.SRC_W(SRC_W)) u_agree_irq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rearm(rearm_irq),
        .gmask(gmask_q), .any_pend(|pend_irq), .arb_src(arb_irq_id),
        .out_q(irq_out), .src_q(irq_src_q)
    );
    birq_agree #(.SRC_W(SRC_W)) u_agree_fiq (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rearm(rearm_fiq),
        .gmask(gmask_q), .any_pend(|pend_fiq), .arb_src(arb_fiq_id),
        .out_q(fiq_out), .src_q(fiq_src_q)
    );

    // read multiplexer
    always_comb begin
        rd_data = '0;
        case (req_addr)
            A_REV:   rd_data = REV_VAL;
            A_CFG:   rd_data = {31'b0, idle_q};
            A_STAT:  rd_data = 32'd1;
            A_SIRQ:  rd_data = 32'(irq_src_q);
            A_SFIQ:  rd_data = 32'(fiq_src_q);
            A_CTL:   rd_data = {29'b0, gmask_q, 2'b00};
            default: rd_data = '0;
        endcase
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (bank_hit[b]) begin
                case (sub)
                    S_RAW:   rd_data = int_lines[b*BANK_W +: BANK_W];
                    S_MASK:  rd_data = mask_all[b*BANK_W +: BANK_W];
                    S_SSET:  rd_data = soft_all[b*BANK_W +: BANK_W];
                    S_PIRQ:  rd_data = pend_irq[b*BANK_W +: BANK_W];
                    S_PFIQ:  rd_data = pend_fiq[b*BANK_W +: BANK_W];
                    default: rd_data = '0;
                endcase
            end
        end
        for (int n = 0; n < NUM_LINES; n++) begin
            if (line_hit[n]) rd_data = {24'b0, prio_arr[n], 1'b0, fiq_sel[n]};
        end
    end
endmodule

// File: rtl/bank_irq_ctrl_chk.sv
// Assertion checker bound to bank_irq_ctrl.
// Observes the handshake outputs and the decode strobes of the top.
module bank_irq_ctrl_chk #(
    parameter int NUM_LINES = 32,
    parameter int SRC_W     = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 soft_rst,
    input logic                 rearm_irq,
    input logic                 rearm_fiq,
    input logic                 gmask_q,
    input logic [NUM_LINES-1:0] pend_irq,
    input logic [NUM_LINES-1:0] pend_fiq,
    input logic                 irq_out,
    input logic                 fiq_out,
    input logic [SRC_W-1:0]     irq_src_q,
    input logic [SRC_W-1:0]     fiq_src_q
);
    p_class_disjoint_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_irq & pend_fiq) == '0);

    p_irq_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(|pend_irq));

    p_fiq_needs_pend_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_out) |-> $past(|pend_fiq));

    p_irq_src_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(irq_out) && !$past(soft_rst)) |-> $stable(irq_src_q));

    p_fiq_src_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!$rose(fiq_out) && !$past(soft_rst)) |-> $stable(fiq_src_q));

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !rearm_irq && !soft_rst) |=> irq_out);

    p_fiq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (fiq_out && !rearm_fiq && !soft_rst) |=> fiq_out);

    p_irq_gmask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> !$past(gmask_q));

    p_fiq_gmask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fiq_out) |-> !$past(gmask_q));
endmodule

bind bank_irq_ctrl bank_irq_ctrl_chk #(.NUM_LINES(NUM_LINES), .SRC_W(SRC_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .rearm_irq(rearm_irq),
    .rearm_fiq(rearm_fiq), .gmask_q(gmask_q), .pend_irq(pend_irq),
    .pend_fiq(pend_fiq), .irq_out(irq_out), .fiq_out(fiq_out),
    .irq_src_q(irq_src_q), .fiq_src_q(fiq_src_q)
);

// File: tb/bank_irq_ctrl_tb_top.sv
// Directed bench for bank_irq_ctrl built with two banks.
module bank_irq_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NB = 2;
    localparam int NL = NB * 32;
    localparam int SW = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_wr = 1'b0;
    logic [11:0]   req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rd_data;
    logic [NL-1:0] int_lines = '0;
    logic [SW-1:0] arb_irq_id = '0;
    logic [SW-1:0] arb_fiq_id = '0;
    logic [NL-1:0] pend_irq, pend_fiq;
    logic [NL*6-1:0] line_prio;
    logic          irq_out, fiq_out;

    int total = 0;
    int bad = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    bank_irq_ctrl #(.NUM_BANKS(NB)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_addr(req_addr),
        .req_wdata(req_wdata), .rd_data(rd_data), .int_lines(int_lines),
        .arb_irq_id(arb_irq_id), .arb_fiq_id(arb_fiq_id),
        .pend_irq(pend_irq), .pend_fiq(pend_fiq), .line_prio(line_prio),
        .irq_out(irq_out), .fiq_out(fiq_out)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        req_wr = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_wr = 1'b0; req_wdata = '0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        @(negedge clk);
        req_addr = a;
        #1;
        check(req, rd_data, exp);
    endtask

    task automatic t_reset_r1();
        rd_chk("R1 rev", 12'h000, 32'h21);
        rd_chk("R1 status", 12'h014, 32'h1);
        rd_chk("R1 mask b0", 12'h084, 32'hFFFF_FFFF);
        rd_chk("R1 mask b1", 12'h0A4, 32'hFFFF_FFFF);
        rd_chk("R1 src irq", 12'h040, 32'h0);
        check("R1 outs low", {30'b0, irq_out, fiq_out}, 32'h0);
    endtask

    task automatic t_idle_r2();
        wr(12'h010, 32'h1);
        rd_chk("R2 idle readback", 12'h010, 32'h1);
    endtask

    task automatic t_mask_r4();
        wr(12'h084, 32'h0000_FF00);
        rd_chk("R4 mask write", 12'h084, 32'h0000_FF00);
        wr(12'h088, 32'h0000_F000);
        rd_chk("R4 mask clear", 12'h084, 32'h0000_0F00);
        wr(12'h08C, 32'h0000_0001);
        rd_chk("R4 mask set", 12'h084, 32'h0000_0F01);
        rd_chk("R4 clear alias reads 0", 12'h088, 32'h0);
        rd_chk("R4 set alias reads 0", 12'h08C, 32'h0);
        wr(12'h084, 32'hFFFF_FFFF);
    endtask

    task automatic t_line_pend_r3_r6();
        wr(12'h10C, (32'd9 << 2) | 32'd1);      // line 3: prio 9, FIQ
        rd_chk("R6 line readback", 12'h10C, 32'h25);
        check("R6 prio port", {26'b0, line_prio[3*6 +: 6]}, 32'd9);
        int_lines[3] = 1'b1; int_lines[4] = 1'b1;
        arb_irq_id = 6'd4; arb_fiq_id = 6'd3;
        wr(12'h084, 32'hFFFF_FFE7);
        rd_chk("R3 raw", 12'h080, 32'h18);
        rd_chk("R3 pend irq", 12'h098, 32'h10);
        rd_chk("R3 pend fiq", 12'h09C, 32'h08);
    endtask

    task automatic t_fire_r7_r8();
        check("R7 irq raised", {31'b0, irq_out}, 32'h1);
        check("R7 fiq raised", {31'b0, fiq_out}, 32'h1);
        rd_chk("R7 irq src", 12'h040, 32'd4);
        rd_chk("R7 fiq src", 12'h044, 32'd3);
        arb_irq_id = 6'd7;
        @(negedge clk);
        check("R8 irq held", {31'b0, irq_out}, 32'h1);
        rd_chk("R8 src held", 12'h040, 32'd4);
        wr(12'h048, 32'h1);
        check("R8 rearm drops irq", {31'b0, irq_out}, 32'h0);
        check("R8 fiq untouched", {31'b0, fiq_out}, 32'h1);
        @(negedge clk);
        check("R8 refire", {31'b0, irq_out}, 32'h1);
        rd_chk("R8 new src", 12'h040, 32'd7);
        rd_chk("R8 fiq src kept", 12'h044, 32'd3);
    endtask

    task automatic t_gmask_r9();
        int_lines = '0;
        wr(12'h048, 32'h3);
        wr(12'h048, 32'h4);
        rd_chk("R9 gmask readback", 12'h048, 32'h4);
        int_lines[4] = 1'b1;
        repeat (3) @(negedge clk);
        check("R9 blocked", {31'b0, irq_out}, 32'h0);
        wr(12'h048, 32'h0);
        @(negedge clk);
        check("R9 fires after unmask", {31'b0, irq_out}, 32'h1);
    endtask

    task automatic t_soft_r5();
        int_lines = '0;
        wr(12'h048, 32'h3);
        arb_irq_id = 6'd40;
        wr(12'h0B0, 32'h100);                   // bank1 bit8 = line 40
        rd_chk("R5 soft readback", 12'h0B0, 32'h100);
        rd_chk("R5 clear alias reads 0", 12'h0B4, 32'h0);
        rd_chk("R5 masked not pending", 12'h0B8, 32'h0);
        check("R5 no fire while masked", {31'b0, irq_out}, 32'h0);
        wr(12'h0A8, 32'h100);
        rd_chk("R5 forced pending", 12'h0B8, 32'h100);
        rd_chk("R5 forced src", 12'h040, 32'd40);
        wr(12'h0B4, 32'h100);
        rd_chk("R5 soft cleared", 12'h0B8, 32'h0);
        wr(12'h048, 32'h1);
        @(negedge clk);
        check("R5 no refire", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_absent_r10();
        wr(12'h0C4, 32'h0);
        rd_chk("R10 absent bank mask", 12'h0C4, 32'h0);
        wr(12'h0D0, 32'hFFFF_FFFF);
        rd_chk("R10 absent bank soft", 12'h0D0, 32'h0);
        wr(12'h200, 32'hFD);
        rd_chk("R10 absent line", 12'h200, 32'h0);
        rd_chk("R10 bank0 mask kept", 12'h084, 32'hFFFF_FFE7);
        rd_chk("R10 bank1 mask kept", 12'h0A4, 32'hFFFF_FEFF);
        rd_chk("R10 bank0 soft kept", 12'h090, 32'h0);
        rd_chk("R10 line0 kept", 12'h100, 32'h0);
        check("R10 no irq", {31'b0, irq_out}, 32'h0);
    endtask

    task automatic t_softreset_r2();
        int_lines[3] = 1'b1;
        @(negedge clk);
        wr(12'h010, 32'h2);
        check("R2 fiq dropped", {31'b0, fiq_out}, 32'h0);
        rd_chk("R2 mask restored", 12'h084, 32'hFFFF_FFFF);
        rd_chk("R2 idle cleared", 12'h010, 32'h0);
        rd_chk("R2 line cleared", 12'h10C, 32'h0);
        rd_chk("R2 src cleared", 12'h044, 32'h0);
        int_lines = '0;
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset_r1();
        t_idle_r2();
        t_mask_r4();
        t_line_pend_r3_r6();
        t_fire_r7_r8();
        t_gmask_r9();
        t_soft_r5();
        t_absent_r10();
        t_softreset_r2();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule